// File: doc/BRIEF.md
# Scan Counter Sequencer

This block sequences a scan counter through an acquisition. It starts idle, then counts a pre-trigger phase if one is requested, waits for a second start, and then counts the post-trigger phase. While it runs it decides when the counter reloads and when it may count. When the run ends under one of the terminating modes, it raises a strobe that withdraws the arm condition. A 24-bit loadable down counter is built in, and its zero value is the terminal count that paces the sequence.

Software arms the block with a one-cycle pulse on `arm_set`. A start strobe then launches the run. The mode inputs choose whether a pre-trigger phase exists and what ends the post-trigger phase:
- the end of a scan;
- the terminal count;
- a single trigger;
- continuous running.

The transfer qualifier `xfer_en` gates every move the counter's terminal count can cause. The gate enable `gate_en` gates counting.

Top module: `scan_ctl`

## Requirements
- R1: A synchronous active-high `rst` puts `state` at idle (code 0), `count` at zero and `armed` low. State codes are: idle = 0, pre-trigger count = 1, wait for second start = 2, post-trigger count = 3.
- R2: In idle, the block moves only when `start1` and `armed` are both high. It goes to state 1 when `pretrig` is high and to state 3 otherwise.
- R3: State 1 moves to state 2 when `tc` and `xfer_en` are both high, and holds otherwise.
- R4: State 2 moves to state 3 when `start2` is high, and holds otherwise.
- R5: State 3 holds while `xfer_en` is low. It also holds while the keep-going term is true. That term is (not `tc` and not `end_scan`) or (not `end_scan` and not `end_tc` and `continuous`). Otherwise state 3 returns to idle.
- R6: `load` is high exactly when (`tc` and `xfer_en`) or `sw_load`.
- R7: `cnt_en` is high exactly when `armed`, `xfer_en` and `gate_en` are all high and either the present or the next state is 1 or 3.
- R8: `disarm` is high only on the cycle in which state 3 moves to idle, and only if `end_scan`, `end_tc` or `trig_once` is high.
- R9: `armed` is set on the edge after an `arm_set` pulse and cleared on the edge after `disarm`. The clear wins when both occur in the same cycle.
- R10: On a clock edge, `count` takes `load_val` when `load` is high. Otherwise it decrements when `cnt_en` is high, and otherwise it holds. Load wins over decrement.
- R11: `tc` is high exactly when `count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_set | input | 1 | Software arm pulse |
| start1 | input | 1 | First start strobe |
| start2 | input | 1 | Second (trigger) start strobe |
| xfer_en | input | 1 | Transfer qualifier |
| gate_en | input | 1 | External gate enable |
| end_scan | input | 1 | Mode: end on end of scan |
| end_tc | input | 1 | Mode: end on terminal count |
| continuous | input | 1 | Mode: continuous |
| pretrig | input | 1 | Mode: pre-trigger phase present |
| trig_once | input | 1 | Mode: single trigger |
| sw_load | input | 1 | Software load strobe |
| load_val | input | 24 | Value loaded into the counter |
| load | output | 1 | Counter reload strobe |
| cnt_en | output | 1 | Counter count enable |
| disarm | output | 1 | Disarm strobe |
| tc | output | 1 | Terminal count (counter at zero) |
| count | output | 24 | Counter value |
| armed | output | 1 | Arm bit |
| state | output | 2 | Sequencer state code |

## Verification
On every cycle the assertions check several cycle-local rules:
- the counter's load priority and its decrement step;
- the state 1 and state 2 transitions;
- that `disarm` appears only while leaving state 3 under a terminating mode;
- that a disarm always leaves `armed` low;
- that `cnt_en` never appears without arm, qualifier and gate.

Only the bench's scenarios can show that a whole run unfolds in the right order. A full run goes through the pre-trigger phase, the wait, the post-trigger count and the final disarm. The scenarios also show that continuous mode keeps counting past terminal count, and that an arm pulse in the same cycle as a disarm loses.

// File: rtl/scan_ctl.sv
module scan_ctl #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm_set,
  input  logic         start1,
  input  logic         start2,
  input  logic         xfer_en,
  input  logic         gate_en,
  input  logic         end_scan,
  input  logic         end_tc,
  input  logic         continuous,
  input  logic         pretrig,
  input  logic         trig_once,
  input  logic         sw_load,
  input  logic [W-1:0] load_val,
  output logic         load,
  output logic         cnt_en,
  output logic         disarm,
  output logic         tc,
  output logic [W-1:0] count,
  output logic         armed,
  output logic [1:0]   state
);
  localparam logic [1:0] S_IDLE = 2'd0, S_PRE = 2'd1, S_WAIT = 2'd2, S_POST = 2'd3;

  logic [1:0] nxt;
  logic       keep_going;

  assign tc = (count == '0);
  assign keep_going = (!tc && !end_scan) || (!end_scan && !end_tc && continuous);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (start1 && armed) nxt = pretrig ? S_PRE : S_POST;
      S_PRE:  if (tc && xfer_en)   nxt = S_WAIT;
      S_WAIT: if (start2)          nxt = S_POST;
      S_POST: if (xfer_en && !keep_going) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign load   = (tc && xfer_en) || sw_load;
  assign cnt_en = armed && xfer_en && gate_en &&
                  (state[0] || nxt[0]);
  assign disarm = (state == S_POST) && (nxt == S_IDLE) &&
                  (end_scan || end_tc || trig_once);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      count <= '0;
      armed <= 1'b0;
    end else begin
      state <= nxt;
      if (load)        count <= load_val;
      else if (cnt_en) count <= count - 1'b1;
      if (disarm)       armed <= 1'b0;
      else if (arm_set) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_ctl_chk.sv
module scan_ctl_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         arm_set,
  input logic         start1,
  input logic         start2,
  input logic         xfer_en,
  input logic         gate_en,
  input logic         end_scan,
  input logic         end_tc,
  input logic         continuous,
  input logic         pretrig,
  input logic         trig_once,
  input logic         sw_load,
  input logic [W-1:0] load_val,
  input logic         load,
  input logic         cnt_en,
  input logic         disarm,
  input logic         tc,
  input logic [W-1:0] count,
  input logic         armed,
  input logic [1:0]   state
);
  p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load)) |-> count == $past(load_val));

  p_decrement_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && $past(cnt_en)) |-> count == $past(count) - 1'b1);

  p_pre_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd1 && tc && xfer_en) |=> state == 2'd2);

  p_wait_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2 && !start2) |=> state == 2'd2);

  p_disarm_where_r8: assert property (@(posedge clk) disable iff (rst)
    disarm |-> (state == 2'd3 && xfer_en && (end_scan || end_tc || trig_once)));

  p_disarm_clears_r9: assert property (@(posedge clk) disable iff (rst)
    disarm |=> !armed);

  p_cen_qual_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_en |-> (armed && xfer_en && gate_en));
endmodule

bind scan_ctl scan_ctl_chk #(.W(W)) i_chk (.*);

// File: tb/test_scan_ctl.sv
module test_scan_ctl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, arm_set, start1, start2, xfer_en, gate_en;
  logic end_scan, end_tc, continuous, pretrig, trig_once, sw_load;
  logic [23:0] load_val, count;
  logic load, cnt_en, disarm, tc, armed;
  logic [1:0] state;

  scan_ctl i_scan_ctl (.*);

  typedef struct packed {
    logic arm, sa, sb, x, g, pre, sl;
    logic [7:0] lv;
    logic eload, ecen, edis;
    logic [1:0] est;
    logic [7:0] ecnt;
    logic earm;
  } vec_t;

  localparam vec_t TBL [14] = '{
    '{1,0,0,0,0,0,0, 8'd0, 0,0,0, 2'd0, 8'd0, 1},
    '{0,1,0,0,1,1,1, 8'd3, 1,0,0, 2'd1, 8'd3, 1},
    '{0,0,0,1,1,1,0, 8'd3, 0,1,0, 2'd1, 8'd2, 1},
    '{0,0,0,1,1,1,0, 8'd3, 0,1,0, 2'd1, 8'd1, 1},
    '{0,0,0,1,1,1,0, 8'd3, 0,1,0, 2'd1, 8'd0, 1},
    '{0,0,0,1,1,1,0, 8'd3, 1,1,0, 2'd2, 8'd3, 1},
    '{0,0,0,1,1,0,0, 8'd3, 0,0,0, 2'd2, 8'd3, 1},
    '{0,0,1,1,1,0,0, 8'd3, 0,1,0, 2'd3, 8'd2, 1},
    '{0,0,0,0,1,0,0, 8'd3, 0,0,0, 2'd3, 8'd2, 1},
    '{0,0,0,1,0,0,0, 8'd3, 0,0,0, 2'd3, 8'd2, 1},
    '{0,0,0,1,1,0,0, 8'd3, 0,1,0, 2'd3, 8'd1, 1},
    '{0,0,0,1,1,0,0, 8'd3, 0,1,0, 2'd3, 8'd0, 1},
    '{0,0,0,1,1,0,0, 8'd3, 1,1,1, 2'd0, 8'd3, 0},
    '{0,1,0,0,1,0,0, 8'd3, 0,0,0, 2'd0, 8'd3, 0}
  };

  int checks = 0, fails = 0;
  logic [7:0] prev_cnt = 8'd0;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    arm_set = v.arm; start1 = v.sa; start2 = v.sb; xfer_en = v.x;
    gate_en = v.g; pretrig = v.pre; sw_load = v.sl; load_val = {16'd0, v.lv};
    #3;
    chk("R11 tc", {23'd0, tc}, {23'd0, prev_cnt == 8'd0});
    chk("R6 load", {23'd0, load}, {23'd0, v.eload});
    chk("R7 cnt_en", {23'd0, cnt_en}, {23'd0, v.ecen});
    chk("R8 disarm", {23'd0, disarm}, {23'd0, v.edis});
    @(posedge clk); #1;
    chk("R2/R3/R4/R5 state", {22'd0, state}, {22'd0, v.est});
    chk("R10 count", count, {16'd0, v.ecnt});
    chk("R9 armed", {23'd0, armed}, {23'd0, v.earm});
    prev_cnt = v.ecnt;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; arm_set = 0; start1 = 0; start2 = 0; xfer_en = 0; gate_en = 0;
    end_scan = 0; end_tc = 1; continuous = 0; pretrig = 0; trig_once = 0;
    sw_load = 0; load_val = '0;
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
    chk("R1 state", {22'd0, state}, 24'd0);
    chk("R1 count", count, 24'd0);
    chk("R1 armed", {23'd0, armed}, 24'd0);

    foreach (TBL[i]) run(TBL[i]);

    // R1 reset from a loaded, non-zero counter
    rst = 1; @(posedge clk); #1; rst = 0;
    chk("R1 count after reset", count, 24'd0);
    chk("R1 state after reset", {22'd0, state}, 24'd0);
    prev_cnt = 8'd0;

    // Continuous mode: R2 direct to post count, R5 stays at terminal count
    end_tc = 0; continuous = 1;
    run('{1,0,0,0,0,0,0, 8'd0, 0,0,0, 2'd0, 8'd0, 1});
    run('{0,1,0,0,1,0,1, 8'd1, 1,0,0, 2'd3, 8'd1, 1});
    run('{0,0,0,1,1,0,0, 8'd1, 0,1,0, 2'd3, 8'd0, 1});
    run('{0,0,0,1,1,0,0, 8'd1, 1,1,0, 2'd3, 8'd1, 1});
    // R5 exit by end of scan; R9 arm pulse loses to disarm
    end_scan = 1;
    run('{1,0,0,1,1,0,0, 8'd1, 0,1,1, 2'd0, 8'd0, 0});

    // R8 single trigger alone disarms
    end_scan = 0; continuous = 0; trig_once = 1;
    run('{1,0,0,0,0,0,1, 8'd2, 1,0,0, 2'd0, 8'd2, 1});
    run('{0,1,0,0,0,0,0, 8'd2, 0,0,0, 2'd3, 8'd2, 1});
    run('{0,0,0,1,0,0,0, 8'd2, 0,0,0, 2'd3, 8'd2, 1});
    run('{0,0,0,1,1,0,0, 8'd2, 0,1,0, 2'd3, 8'd1, 1});
    run('{0,0,0,1,1,0,0, 8'd2, 0,1,0, 2'd3, 8'd0, 1});
    run('{0,0,0,1,1,0,0, 8'd2, 1,1,1, 2'd0, 8'd2, 0});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule